// File: doc/BRIEF.md
# Cascaded Watchdog with Programmable Reset Pulse

This block supervises host software with a chain of three 16-bit down-counters. A prescaler turns the system clock into an enable pulse at one sixteenth of its rate. That pulse steps the first counter, and each terminal count of the first counter steps the second. Software loads the reload values, arms the watchdog and then writes a refresh strobe at regular intervals. Each refresh restarts both timeout counters. If the refreshes stop, the second counter runs out. When reset output is enabled, the block then drives a complementary reset pair.

The third counter sets how long the reset pulse lasts. It is loaded when the pulse starts and counts only while the pulse is active. Its clock is either half the system clock (the default) or one sixteenth of it. Writing the clock-select offset picks the slow rate, and reading the same offset returns to the fast rate. The pulse ends at the first of three events: the third counter runs out, the external bus reset input is high at a clock edge, or power-on reset is applied. When the pulse ends, the watchdog disarms itself. Software must arm it again before the next timeout can happen.

Register offsets: 0x00, 0x04 and 0x08 hold the reload values for counters 0, 1 and 2. 0x0C is the clock-select latch. 0x10 is control, with bit 0 = arm and bit 1 = reset enable. 0x14 is the refresh strobe, where any write counts. A reload value of 0 stands for 65,536 and can only come from power-on reset.

Top module: `wdog_cascade`

## Requirements
- R1: After power-on reset, wdrst_o is 0 and wdrst_n_o is 1, the watchdog is disarmed, and the reset-width clock is the fast rate (system clock / 2).
- R2: The arm write is a control write with bit 0 = 1 while disarmed, and it loads counters 0 and 1. If no refresh follows, wdrst_o is first seen high exactly 16*N0*N1 clock edges after the edge that takes the arm write.
- R3: A write of 0 or 1 to a reload offset (0x00, 0x04, 0x08) is ignored, and the previous reload value stays.
- R4: A refresh write (offset 0x14) while armed and not in reset reloads counters 0 and 1 and restarts the prescaler. The timeout is then 16*N0*N1 edges counted from the refresh edge.
- R5: wdrst_n_o is always the complement of wdrst_o.
- R6: With control bit 1 = 0, a timeout does not assert the reset pair. The timeout counters keep cycling, so setting bit 1 later makes the next timeout assert the pair.
- R7: The reset pair stays active for D*N2 clock cycles, with D = 2 at the fast rate and D = 16 at the slow rate.
- R8: A write to offset 0x0C selects the slow rate. A read from offset 0x0C selects the fast rate.
- R9: A high bus_rst_i at a clock edge while reset is active ends the reset at that edge.
- R10: Asserting rst_ni ends an active reset at once and returns the clock select to the fast rate.
- R11: Refresh writes made while reset is active have no effect on the pulse width or on later behaviour.
- R12: When the reset pulse ends, the watchdog disarms. No further timeout happens until a new arm write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| bus_rst_i | input | 1 | External bus reset pulse that ends an active reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W (5) | Register byte offset |
| wdata_i | input | CNT_W (16) | Register write data |
| wdrst_o | output | 1 | Watchdog reset, active high |
| wdrst_n_o | output | 1 | Watchdog reset, active low |

## Verification
The hardest state to reach from the ports is a reset pulse that is cut short. That covers a pulse ended by the bus reset or by power-on reset, and a pulse that receives refresh writes while active. Each needs a real timeout first, at a known moment. The bench therefore uses the smallest legal reload values to reach the timeout edge quickly. It uses a long slow-rate pulse so that there is time to inject the bus reset, power-on reset or refresh strobe in the middle of the pulse. It then measures what remains of the pulse and checks that the watchdog stays quiet until it is armed again.

// File: rtl/wdc_pkg.sv
package wdc_pkg;

    localparam int unsigned WDC_CNT_W  = 16;
    localparam int unsigned WDC_ADDR_W = 5;
    localparam int unsigned WDC_NUM_CNT = 3;

    // Register offsets (byte addresses)
    localparam logic [4:0] OFS_RELOAD0 = 5'h00;
    localparam logic [4:0] OFS_CLKSEL  = 5'h0C;
    localparam logic [4:0] OFS_CTRL    = 5'h10;
    localparam logic [4:0] OFS_KICK    = 5'h14;

    localparam int unsigned CTRL_ARM_BIT   = 0;
    localparam int unsigned CTRL_RSTEN_BIT = 1;

    typedef struct packed {
        logic armed;
        logic rst_en;
        logic slow_sel;
    } wdc_ctrl_t;

    typedef struct packed {
        logic active;
        logic out_hi;
        logic out_lo_n;
    } wdc_rst_t;

endpackage

// File: rtl/wdc_prescale.sv
module wdc_prescale #(
    parameter int unsigned DIV = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic restart_i,
    input  logic fast_i,
    output logic tick_o
);
    localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [PW-1:0] phase;
    } pre_t;

    pre_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (restart_i) begin
            s_d.phase = '0;
        end else begin
            s_d.phase = s_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tick_o = fast_i ? s_q.phase[0] : (s_q.phase == PW'(DIV - 1));

    // a slow tick is never followed directly by another
    AST_SLOW_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!fast_i && tick_o && !restart_i) |=> !(s_q.phase == PW'(DIV - 1)))
        else $error("slow tick spacing"); // R2

endmodule

// File: rtl/wdc_down_counter.sv
module wdc_down_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic         en_i,
    input  logic         tick_i,
    input  logic [W-1:0] reload_i,
    output logic         term_o,
    output logic [W-1:0] count_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_t;

    cnt_t s_d, s_q;
    logic at_one;

    assign at_one = (s_q.cnt == W'(1));

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.cnt = reload_i;
        end else if (en_i && tick_i) begin
            if (at_one) begin
                s_d.cnt = reload_i;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign term_o  = en_i && tick_i && at_one && !load_i;
    assign count_o = s_q.cnt;

    AST_TERM_RELOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        term_o |=> (count_o == $past(reload_i)))
        else $error("counter did not reload at terminal count"); // R2

endmodule

// File: rtl/wdc_regs.sv
module wdc_regs
    import wdc_pkg::*;
#(
    parameter int unsigned CNT_W  = WDC_CNT_W,
    parameter int unsigned ADDR_W = WDC_ADDR_W,
    parameter int unsigned NCNT   = WDC_NUM_CNT
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  wdata_i,
    input  logic              rst_active_i,
    input  logic              release_i,
    output logic [CNT_W-1:0]  reload0_o,
    output logic [CNT_W-1:0]  reload1_o,
    output logic [CNT_W-1:0]  reload2_o,
    output logic              armed_o,
    output logic              rst_en_o,
    output logic              slow_sel_o,
    output logic              start_o
);
    typedef struct packed {
        logic [NCNT-1:0][CNT_W-1:0] reload;
        wdc_ctrl_t                  ctrl;
    } regs_t;

    regs_t s_d, s_q;

    logic hit_ctrl, hit_kick, hit_clk;
    logic arm_req, kick_ok;

    assign hit_ctrl = (addr_i == ADDR_W'(OFS_CTRL));
    assign hit_kick = (addr_i == ADDR_W'(OFS_KICK));
    assign hit_clk  = (addr_i == ADDR_W'(OFS_CLKSEL));

    assign arm_req = wr_en_i && hit_ctrl && wdata_i[CTRL_ARM_BIT] && !s_q.ctrl.armed;
    assign kick_ok = wr_en_i && hit_kick && s_q.ctrl.armed && !rst_active_i;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < int'(NCNT); i++) begin
            if (wr_en_i && (addr_i == ADDR_W'(OFS_RELOAD0 + 5'(4 * i)))
                    && (wdata_i > CNT_W'(1))) begin
                s_d.reload[i] = wdata_i;
            end
        end
        if (wr_en_i && hit_ctrl) begin
            s_d.ctrl.armed  = wdata_i[CTRL_ARM_BIT];
            s_d.ctrl.rst_en = wdata_i[CTRL_RSTEN_BIT];
        end
        if (release_i) begin
            s_d.ctrl.armed = 1'b0;
        end
        if (wr_en_i && hit_clk) begin
            s_d.ctrl.slow_sel = 1'b1;
        end
        if (rd_en_i && hit_clk) begin
            s_d.ctrl.slow_sel = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign reload0_o  = s_q.reload[0];
    assign reload1_o  = s_q.reload[1];
    assign reload2_o  = s_q.reload[2];
    assign armed_o    = s_q.ctrl.armed;
    assign rst_en_o   = s_q.ctrl.rst_en;
    assign slow_sel_o = s_q.ctrl.slow_sel;
    assign start_o    = arm_req || kick_ok;

    for (genvar g = 0; g < int'(NCNT); g++) begin : g_chk
        AST_RELOAD_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
            s_q.reload[g] != CNT_W'(1))
            else $error("reload value of one stored"); // R3
    end

    AST_CLKSEL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && hit_clk && !rd_en_i) |=> slow_sel_o)
        else $error("clock select not set"); // R8

    AST_CLKSEL_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && hit_clk) |=> !slow_sel_o)
        else $error("clock select not cleared"); // R8

    AST_KICK_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_active_i |-> !start_o)
        else $error("restart during active reset"); // R11

endmodule

// File: rtl/wdog_cascade.sv
module wdog_cascade
    import wdc_pkg::*;
#(
    parameter int unsigned CNT_W    = WDC_CNT_W,
    parameter int unsigned ADDR_W   = WDC_ADDR_W,
    parameter int unsigned SLOW_DIV = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_rst_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  wdata_i,
    output logic              wdrst_o,
    output logic              wdrst_n_o
);
    localparam int unsigned NCNT    = WDC_NUM_CNT;
    localparam int unsigned C_TOUT0 = 0;
    localparam int unsigned C_TOUT1 = 1;
    localparam int unsigned C_WIDTH = 2;

    logic [CNT_W-1:0] reload0, reload1, reload2;
    logic armed, rst_en, slow_sel, start;
    logic tick_tout, tick_width;
    logic assert_ev, release_ev;

    logic [NCNT-1:0]  cnt_load, cnt_en, cnt_tick, cnt_term;
    logic [CNT_W-1:0] cnt_reload [NCNT];
    logic [CNT_W-1:0] cnt_val    [NCNT];

    wdc_rst_t s_d, s_q;

    wdc_regs #(
        .CNT_W (CNT_W),
        .ADDR_W(ADDR_W),
        .NCNT  (NCNT)
    ) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_en_i     (wr_en_i),
        .rd_en_i     (rd_en_i),
        .addr_i      (addr_i),
        .wdata_i     (wdata_i),
        .rst_active_i(s_q.active),
        .release_i   (release_ev),
        .reload0_o   (reload0),
        .reload1_o   (reload1),
        .reload2_o   (reload2),
        .armed_o     (armed),
        .rst_en_o    (rst_en),
        .slow_sel_o  (slow_sel),
        .start_o     (start)
    );

    // timeout path: phase restarts on arm or refresh
    wdc_prescale #(.DIV(SLOW_DIV)) u_pre_tout (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .restart_i(start),
        .fast_i   (1'b0),
        .tick_o   (tick_tout)
    );

    // reset-width path: phase restarts when the pulse begins
    wdc_prescale #(.DIV(SLOW_DIV)) u_pre_width (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .restart_i(assert_ev),
        .fast_i   (!slow_sel),
        .tick_o   (tick_width)
    );

    assign cnt_reload[C_TOUT0] = reload0;
    assign cnt_reload[C_TOUT1] = reload1;
    assign cnt_reload[C_WIDTH] = reload2;

    assign cnt_load[C_TOUT0] = start;
    assign cnt_load[C_TOUT1] = start;
    assign cnt_load[C_WIDTH] = assert_ev;

    assign cnt_en[C_TOUT0] = armed && !s_q.active;
    assign cnt_en[C_TOUT1] = armed && !s_q.active;
    assign cnt_en[C_WIDTH] = s_q.active;

    assign cnt_tick[C_TOUT0] = tick_tout;
    assign cnt_tick[C_TOUT1] = cnt_term[C_TOUT0];
    assign cnt_tick[C_WIDTH] = tick_width;

    for (genvar g = 0; g < int'(NCNT); g++) begin : g_cnt
        wdc_down_counter #(.W(CNT_W)) u_cnt (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .load_i  (cnt_load[g]),
            .en_i    (cnt_en[g]),
            .tick_i  (cnt_tick[g]),
            .reload_i(cnt_reload[g]),
            .term_o  (cnt_term[g]),
            .count_o (cnt_val[g])
        );
    end

    assign assert_ev  = cnt_term[C_TOUT1] && rst_en && !s_q.active;
    assign release_ev = s_q.active && (bus_rst_i || cnt_term[C_WIDTH]);

    always_comb begin
        s_d = s_q;
        if (release_ev) begin
            s_d.active   = 1'b0;
            s_d.out_hi   = 1'b0;
            s_d.out_lo_n = 1'b1;
        end else if (assert_ev) begin
            s_d.active   = 1'b1;
            s_d.out_hi   = 1'b1;
            s_d.out_lo_n = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{active: 1'b0, out_hi: 1'b0, out_lo_n: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign wdrst_o   = s_q.out_hi;
    assign wdrst_n_o = s_q.out_lo_n;

    AST_OUT_COMPLEMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wdrst_o != wdrst_n_o)
        else $error("reset pair not complementary"); // R5

    AST_BUS_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wdrst_o && bus_rst_i) |=> !wdrst_o)
        else $error("bus reset did not end pulse"); // R9

    AST_NO_RST_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rst_en && !wdrst_o) |=> !wdrst_o)
        else $error("reset asserted while disabled"); // R6

    AST_DISARM_ON_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(wdrst_o) |-> !armed)
        else $error("still armed after pulse"); // R12

    AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!armed && !start) |=> ($stable(cnt_val[C_TOUT0]) && $stable(cnt_val[C_TOUT1])))
        else $error("timeout counters moved while disarmed"); // R12

    AST_WIDTH_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wdrst_o) |-> (cnt_val[C_WIDTH] == $past(reload2)))
        else $error("width counter not loaded at pulse start"); // R7

endmodule

// File: tb/wdog_cascade_tb.sv
module wdog_cascade_tb;
    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        bus_rst_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic        rd_en_i = 1'b0;
    logic [4:0]  addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic        wdrst_o, wdrst_n_o;

    int n_chk = 0;
    int n_err = 0;
    int cmp_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wdog_cascade u_dut (
        .clk_i    (clk),
        .rst_ni   (rst_ni),
        .bus_rst_i(bus_rst_i),
        .wr_en_i  (wr_en_i),
        .rd_en_i  (rd_en_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .wdrst_o  (wdrst_o),
        .wdrst_n_o(wdrst_n_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (wdrst_o == wdrst_n_o) cmp_bad++;
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        step();
        wr_en_i = 1'b0;
    endtask

    task automatic bus_rd(input logic [4:0] a);
        @(negedge clk);
        rd_en_i = 1'b1; addr_i = a;
        step();
        rd_en_i = 1'b0;
    endtask

    task automatic cfg(input int n0, input int n1, input int n2);
        bus_wr(5'h00, 16'(n0));
        bus_wr(5'h04, 16'(n1));
        bus_wr(5'h08, 16'(n2));
    endtask

    task automatic set_slow(input bit s);
        if (s) bus_wr(5'h0C, 16'h0); else bus_rd(5'h0C);
    endtask

    task automatic wait_high(output int t);
        t = 0;
        while (!wdrst_o && t < 5000) begin step(); t++; end
    endtask

    task automatic width(output int w);
        w = 0;
        while (wdrst_o && w < 5000) begin w++; step(); end
    endtask

    task automatic quiet(input int n, input string req);
        int hits = 0;
        for (int i = 0; i < n; i++) begin
            if (wdrst_o) hits++;
            step();
        end
        chk(hits == 0, req, hits, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int t, w;
        repeat (3) @(negedge clk);
        chk(wdrst_o == 1'b0 && wdrst_n_o == 1'b1, "R1 during reset", wdrst_o, 0);
        rst_ni = 1'b1;
        repeat (2) @(negedge clk);
        chk(wdrst_o == 1'b0 && wdrst_n_o == 1'b1, "R1 after reset", wdrst_o, 0);
        quiet(100, "R1 disarmed after reset");

        // sweep small configurations: R2, R7, R8, R12
        for (int n0 = 2; n0 <= 3; n0++) begin
            for (int n1 = 2; n1 <= 3; n1++) begin
                for (int k = 0; k < 2; k++) begin
                    for (int s = 0; s < 2; s++) begin
                        int n2 = (k == 0) ? 2 : 5;
                        cfg(n0, n1, n2);
                        set_slow(s != 0);
                        bus_wr(5'h10, 16'h3);
                        wait_high(t);
                        chk(t == 16 * n0 * n1, "R2 timeout", t, 16 * n0 * n1);
                        width(w);
                        chk(w == ((s != 0) ? 16 : 2) * n2, "R7/R8 width", w,
                            ((s != 0) ? 16 : 2) * n2);
                        quiet(16 * n0 * n1 + 32, "R12 disarmed");
                    end
                end
            end
        end

        // R3: illegal reload writes ignored
        cfg(3, 2, 2);
        bus_wr(5'h00, 16'd1);
        bus_wr(5'h00, 16'd0);
        bus_wr(5'h04, 16'd1);
        bus_wr(5'h08, 16'd0);
        set_slow(1'b0);
        bus_wr(5'h10, 16'h3);
        wait_high(t);
        chk(t == 96, "R3 timeout", t, 96);
        width(w);
        chk(w == 4, "R3 width", w, 4);

        // R4: refresh restarts the timeout
        cfg(2, 3, 2);
        bus_wr(5'h10, 16'h3);
        quiet(60, "R4 before refresh");
        bus_wr(5'h14, 16'h0);
        wait_high(t);
        chk(t == 96, "R4 timeout from refresh", t, 96);
        width(w);
        chk(w == 4, "R4 width", w, 4);

        // R6: reset disabled, then enabled
        cfg(2, 2, 3);
        bus_wr(5'h10, 16'h1);
        quiet(200, "R6 disabled");
        bus_wr(5'h10, 16'h3);
        wait_high(t);
        chk(t > 0 && t <= 64, "R6 next timeout", t, 64);
        width(w);
        chk(w == 6, "R6 width", w, 6);

        // R11: refresh during reset ignored
        cfg(2, 2, 20);
        set_slow(1'b1);
        bus_wr(5'h10, 16'h3);
        wait_high(t);
        chk(t == 64, "R11 timeout", t, 64);
        bus_wr(5'h14, 16'h0);
        width(w);
        chk(w == 318, "R11 width", w, 318);
        quiet(100, "R11/R12 quiet after");

        // R9: bus reset ends pulse
        cfg(2, 2, 100);
        bus_wr(5'h10, 16'h3);
        wait_high(t);
        repeat (5) step();
        bus_rst_i = 1'b1;
        step();
        bus_rst_i = 1'b0;
        chk(wdrst_o == 1'b0 && wdrst_n_o == 1'b1, "R9 bus release", wdrst_o, 0);
        quiet(100, "R9/R12 quiet after");

        // R10: power-on reset ends pulse, clears clock select
        cfg(2, 2, 100);
        set_slow(1'b1);
        bus_wr(5'h10, 16'h3);
        wait_high(t);
        repeat (3) step();
        rst_ni = 1'b0;
        #1;
        chk(wdrst_o == 1'b0 && wdrst_n_o == 1'b1, "R10 por release", wdrst_o, 0);
        @(negedge clk);
        rst_ni = 1'b1;
        cfg(2, 2, 2);
        bus_wr(5'h10, 16'h3);
        wait_high(t);
        chk(t == 64, "R10 timeout after por", t, 64);
        width(w);
        chk(w == 4, "R10 fast rate after por", w, 4);

        chk(cmp_bad == 0, "R5 complement", cmp_bad, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule